// File: doc/BRIEF.md
# Strobe Gate Interlock and Drive Sequencer

This block sits between a host processor and the gate of the external switch that fires a flash tube. Its job is to stop a stray strobe request from firing the tube while the supply is still coming up. The gate may only turn on after an arming sequence has been seen on the supply-good flag, the charge-enable input and the active-low charge-complete status. Once armed, the block follows the trigger request. It drives two gate outputs: a pull-up (source) and a pull-down (sink).

All four control inputs may change at any time, so each passes through a synchronizer. The arming tracker records whether charging has been observed disabled and whether charge-complete has been observed asserted. Both records are lost whenever the supply drops below its threshold.

The drive sequencer steps through off, lead dead band, on and trail dead band. It never enables source and sink together. Under undervoltage it releases both outputs.

Top module: `strobe_gate_ctl`

## Requirements
- R1: While rst_n is low, and at any time uvlo_ok (synchronized) is low, both gate_src and gate_snk read 0. Once supply is good and the gate is not firing, gate_snk reads 1 and gate_src reads 0.
- R2: gate_src stays 0 while the block is unarmed, whatever trigger does.
- R3: Arming needs two things after uvlo_ok goes high: charge must have been observed low, and done_n must have been observed low. Either condition missing keeps the gate off.
- R4: When armed, a firing request is trigger high with charge low. Every other combination of trigger and charge gives gate_src 0 and, after the dead band, gate_snk 1. Raising charge during a firing ends it.
- R5: Within two clock edges of uvlo_ok falling, both outputs read 0. They stay 0 for as long as uvlo_ok is low, even if trigger toggles.
- R6: A low on uvlo_ok clears both arming records. After the supply returns, the gate stays off until done_n has been seen low again.
- R7: gate_src and gate_snk are never 1 in the same cycle.
- R8: Each handover between sink and source has a dead band of DEAD_CYCLES cycles (default 1) in which both outputs are 0.
- R9: Latency is counted in clock edges after an input change, with SYNC_STAGES = 2. When armed, gate_src rises on the 4th edge after the request appears. It falls on the 3rd edge after the request is withdrawn, and gate_snk rises one edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_ok | input | 1 | Supply above undervoltage threshold (1 = good) |
| charge | input | 1 | Charger enable request (1 = charging) |
| done_n | input | 1 | Charge-complete status, active low |
| trigger | input | 1 | Strobe fire request (1 = fire) |
| gate_src | output | 1 | Gate pull-up enable |
| gate_snk | output | 1 | Gate pull-down enable |

## Verification
If an arming record is set when it should not be, the gate fires during the power-up window. This shows at gate_src four edges after trigger rises, on a part that never saw done_n low. If a record fails to clear, the same early firing appears after a brown-out. If the sequencer state is wrong, the dead band is skipped, which appears at the ports as source and sink overlapping, or as a handover with no idle cycle. The sweeps cover every pair of arming histories and every trigger/charge combination, and they check the exact edge on which each output changes.

// File: rtl/strobe_gate_pkg.sv
package strobe_gate_pkg;

  typedef enum logic [1:0] {
    DRV_OFF   = 2'd0,
    DRV_LEAD  = 2'd1,
    DRV_ON    = 2'd2,
    DRV_TRAIL = 2'd3
  } drv_state_t;

  localparam int unsigned CTL_W = 4;
  localparam int unsigned BIT_UV  = 0;
  localparam int unsigned BIT_CHG = 1;
  localparam int unsigned BIT_DNN = 2;
  localparam int unsigned BIT_TRG = 3;

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] stage_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = d_async;
      end else begin : g_rest
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q[s] <= RST_VAL;
        end else begin
          stage_q[s] <= stage_d[s];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];

endmodule

// File: rtl/strobe_arm.sv
module strobe_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok_s,
  input  logic charge_s,
  input  logic done_n_s,
  input  logic trig_s,
  output logic armed,
  output logic fire_req
);

  logic chg_seen_q, chg_seen_d;
  logic dn_seen_q, dn_seen_d;
  logic chg_low_now, dn_low_now;
  logic chg_seen_eff, dn_seen_eff;

  always_comb begin
    chg_low_now  = uv_ok_s & ~charge_s;
    dn_low_now   = uv_ok_s & ~done_n_s;
    chg_seen_eff = chg_seen_q | chg_low_now;
    dn_seen_eff  = dn_seen_q | dn_low_now;
    chg_seen_d   = uv_ok_s & chg_seen_eff;
    dn_seen_d    = uv_ok_s & dn_seen_eff;
    armed        = uv_ok_s & chg_seen_eff & dn_seen_eff;
    fire_req     = armed & trig_s & ~charge_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chg_seen_q <= 1'b0;
      dn_seen_q  <= 1'b0;
    end else begin
      chg_seen_q <= chg_seen_d;
      dn_seen_q  <= dn_seen_d;
    end
  end

  AST_ARM_CLEAR_UV: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok_s |=> (!chg_seen_q && !dn_seen_q)); // R6

  AST_ARM_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_ok_s && !dn_seen_q && done_n_s) |-> !fire_req); // R3

endmodule

// File: rtl/strobe_drive.sv
module strobe_drive
  import strobe_gate_pkg::*;
#(
  parameter int unsigned DEAD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uv_ok_s,
  input  logic fire_req,
  output logic gate_src,
  output logic gate_snk
);

  localparam int unsigned CW = (DEAD_CYCLES > 1) ? $clog2(DEAD_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(DEAD_CYCLES - 1);

  drv_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!uv_ok_s) begin
      st_d   = DRV_OFF;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case (st_q)
        DRV_OFF: begin
          if (fire_req) begin
            st_d   = DRV_LEAD;
            cnt_d  = CNT_LOAD;
            cnt_en = 1'b1;
          end
        end
        DRV_LEAD: begin
          if (!fire_req) begin
            st_d = DRV_OFF;
          end else if (cnt_zero) begin
            st_d = DRV_ON;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        DRV_ON: begin
          if (!fire_req) begin
            st_d   = DRV_TRAIL;
            cnt_d  = CNT_LOAD;
            cnt_en = 1'b1;
          end
        end
        DRV_TRAIL: begin
          if (cnt_zero) begin
            st_d = DRV_OFF;
          end else begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: st_d = DRV_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= DRV_OFF;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign gate_src = uv_ok_s & (st_q == DRV_ON);
  assign gate_snk = uv_ok_s & (st_q == DRV_OFF);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_src && gate_snk)); // R7

  AST_LEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_src) |-> !$past(gate_snk)); // R8

  AST_TRAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_snk) |-> !$past(gate_src)); // R8

  AST_UV_RESETS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok_s |=> (st_q == DRV_OFF)); // R5

endmodule

// File: rtl/strobe_gate_ctl.sv
module strobe_gate_ctl
  import strobe_gate_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEAD_CYCLES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_ok,
  input  logic charge,
  input  logic done_n,
  input  logic trigger,
  output logic gate_src,
  output logic gate_snk
);

  localparam logic [CTL_W-1:0] SYNC_RST = CTL_W'(1) << BIT_DNN;

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic uv_ok_s, charge_s, done_n_s, trig_s;
  logic armed, fire_req;

  always_comb begin
    ctl_raw          = '0;
    ctl_raw[BIT_UV]  = uvlo_ok;
    ctl_raw[BIT_CHG] = charge;
    ctl_raw[BIT_DNN] = done_n;
    ctl_raw[BIT_TRG] = trigger;
  end

  strobe_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (SYNC_RST)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ctl_raw),
    .d_sync  (ctl_s)
  );

  assign uv_ok_s  = ctl_s[BIT_UV];
  assign charge_s = ctl_s[BIT_CHG];
  assign done_n_s = ctl_s[BIT_DNN];
  assign trig_s   = ctl_s[BIT_TRG];

  strobe_arm u_arm (
    .clk      (clk),
    .rst_n    (rst_n),
    .uv_ok_s  (uv_ok_s),
    .charge_s (charge_s),
    .done_n_s (done_n_s),
    .trig_s   (trig_s),
    .armed    (armed),
    .fire_req (fire_req)
  );

  strobe_drive #(
    .DEAD_CYCLES (DEAD_CYCLES)
  ) u_drive (
    .clk      (clk),
    .rst_n    (rst_n),
    .uv_ok_s  (uv_ok_s),
    .fire_req (fire_req),
    .gate_src (gate_src),
    .gate_snk (gate_snk)
  );

  AST_FIRE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    gate_src |-> $past(armed)); // R2

  AST_FIRE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    gate_src |-> $past(fire_req)); // R4

  AST_UV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !uv_ok_s |-> (!gate_src && !gate_snk)); // R5

endmodule

// File: tb/sim_strobe_gate_ctl.sv
module sim_strobe_gate_ctl;

  logic clk = 1'b0;
  logic rst_n;
  logic uvlo_ok, charge, done_n, trigger;
  logic gate_src, gate_snk;
  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  strobe_gate_ctl u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .uvlo_ok  (uvlo_ok),
    .charge   (charge),
    .done_n   (done_n),
    .trigger  (trigger),
    .gate_src (gate_src),
    .gate_snk (gate_snk)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic es, input logic ek);
    checks++;
    if (gate_src !== es || gate_snk !== ek) begin
      errors++;
      $display("FAIL %s: src/snk actual %b%b expected %b%b at %0t",
               tag, gate_src, gate_snk, es, ek, $time);
    end
  endtask

  task automatic power_cycle();
    uvlo_ok = 1'b0; trigger = 1'b0; charge = 1'b1; done_n = 1'b1;
    step(4);
    uvlo_ok = 1'b1;
    step(3);
  endtask

  task automatic pulse_done();
    done_n = 1'b0;
    step(1);
    done_n = 1'b1;
    step(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; uvlo_ok = 1'b0; charge = 1'b0; done_n = 1'b1; trigger = 1'b0;
    step(2);
    chk("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(3);
    chk("R1 supply low after reset", 1'b0, 1'b0);

    // Supply good, never armed by done_n
    uvlo_ok = 1'b1; charge = 1'b1;
    step(3);
    chk("R1 idle sink on", 1'b0, 1'b1);
    trigger = 1'b1; charge = 1'b0;
    step(6);
    chk("R2 R3 no fire without done_n low", 1'b0, 1'b1);

    // Sweep arming history: done_n seen low or not
    for (int d = 0; d < 2; d++) begin
      power_cycle();
      if (d == 1) pulse_done();
      charge = 1'b0; trigger = 1'b1;
      step(2);
      chk("R9 no change after 2 edges", 1'b0, 1'b1);
      step(1);
      chk("R8 R3 lead dead band", 1'b0, (d == 1) ? 1'b0 : 1'b1);
      step(1);
      chk("R9 R3 source on 4th edge", (d == 1) ? 1'b1 : 1'b0, (d == 1) ? 1'b0 : 1'b1);
    end

    // Armed: sweep trigger x charge
    for (int t = 0; t < 2; t++) begin
      for (int c = 0; c < 2; c++) begin
        logic f;
        trigger = t[0]; charge = c[0];
        f = t[0] & ~c[0];
        step(6);
        chk("R4 trigger/charge sweep", f, ~f);
      end
    end

    // Fall timing
    trigger = 1'b1; charge = 1'b0;
    step(6);
    chk("R4 firing", 1'b1, 1'b0);
    trigger = 1'b0;
    step(2);
    chk("R9 still on after 2 edges", 1'b1, 1'b0);
    step(1);
    chk("R9 R8 trail dead band", 1'b0, 1'b0);
    step(1);
    chk("R8 sink back", 1'b0, 1'b1);

    // Undervoltage while firing
    trigger = 1'b1;
    step(6);
    chk("R4 firing again", 1'b1, 1'b0);
    uvlo_ok = 1'b0;
    step(1);
    chk("R5 one edge after drop", 1'b1, 1'b0);
    step(1);
    chk("R5 both released", 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) begin
      trigger = ~trigger;
      step(1);
      chk("R5 toggle under UV", 1'b0, 1'b0);
    end

    // Return of supply: records cleared
    trigger = 1'b1; charge = 1'b0; done_n = 1'b1; uvlo_ok = 1'b1;
    step(8);
    chk("R6 no fire after brown-out", 1'b0, 1'b1);
    pulse_done();
    step(3);
    chk("R6 fires after re-arm", 1'b1, 1'b0);

    // Charge rising ends firing
    charge = 1'b1;
    step(2);
    chk("R4 charge high not yet seen", 1'b1, 1'b0);
    step(1);
    chk("R4 charge high ends firing", 1'b0, 1'b0);
    step(1);
    chk("R4 sink after abort", 1'b0, 1'b1);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule